// File: doc/BRIEF.md
# Down-Counting Interval Timer with Expiry Acknowledge

This block is a 32-bit interval timer that software controls through a small word-addressed register bus. Software writes a reload value and then sets an enable bit. The counter takes the reload value and decrements once per clock. When the count passes from one to zero, an expiry flag is set. A single interrupt line follows that flag whenever interrupts are enabled.

There are two ways to restart the timer. In acknowledge mode the counter stops at zero. It waits there until software writes a one to the expiry flag, and only then starts a new period. Each interval therefore includes the time software takes to service the expiry. In periodic mode the counter reloads itself at the moment of expiry. Expiries then arrive at a fixed spacing, whenever software clears the flag.

Register map (byte offsets): 0x0 reload value, 0x4 control, 0x8 live count (read only), 0xC status.

Top module: `tick_slicer`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is low.
- R2: The reload register reads back what was written. The control register reads interrupt-enable at bit 24, timer-enable at bit 25 and periodic mode at bit 26. All other control bits read 0, so writing 0xFFFFFFFF reads back 0x07000000.
- R3: A write that sets timer-enable while it was clear loads the reload value into the count. Then the count drops by one on each following clock.
- R4: With a reload value N, the status flag (bit 24 of status, 0x01000000) is set N clocks after the loading write. In acknowledge mode the count then reads 0.
- R5: `irq` is high exactly when both the status flag and interrupt-enable are set. Setting interrupt-enable while the flag is already set raises `irq` right after that write.
- R6: In acknowledge mode the count stays at 0 after expiry until a one is written to status bit 24. That write clears the flag and `irq`, and loads the reload value. The next expiry follows N clocks later.
- R7: In periodic mode the count reloads on expiry with no acknowledge. Expiries are spaced N clocks apart, independent of when the flag is cleared.
- R8: Writing a zero to status bit 24 leaves the flag and the count unchanged.
- R9: Clearing timer-enable freezes the count. Setting it again reloads the count.
- R10: If an expiry and a one-write to the flag fall on the same clock, the flag stays set.
- R11: A reload value of 0 never sets the flag.
- R12: In acknowledge mode, a one-write to the flag while the count is nonzero does not restart the count; the count keeps decrementing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| irq | output | 1 | Level interrupt request |

## Verification
Directed sequences cover the following cases:
- acknowledge mode versus periodic mode with the same reload value, which separates stretched periods from fixed periods;
- a late acknowledge, which must stretch only the acknowledge-mode period;
- an acknowledge landing on the expiry clock, which checks that an expiry is never lost;
- a zero reload value, and a zero written to the flag.

Randomised trials pick the reload value, the mode, interrupt-enable and the acknowledge delay. The expected expiry clock and count are predicted arithmetically from the loading or acknowledging write, so an off-by-one in the load or reload path shows up as a mismatch in flag timing.

// File: rtl/tick_slicer_pkg.sv
package tick_slicer_pkg;
    localparam int unsigned REG_IDX_W = 2;
    localparam int unsigned IDX_LSB   = 2;

    // Control and status bit positions
    localparam int unsigned BIT_IEN  = 24;
    localparam int unsigned BIT_TEN  = 25;
    localparam int unsigned BIT_RUN  = 26;
    localparam int unsigned BIT_FLAG = 24;

    typedef enum logic [REG_IDX_W-1:0] {
        IDX_RELOAD = 2'd0,
        IDX_CTRL   = 2'd1,
        IDX_COUNT  = 2'd2,
        IDX_STATUS = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic run;
        logic ten;
        logic ien;
    } ctrl_t;
endpackage

// File: rtl/tick_slicer_regs.sv
module tick_slicer_regs
    import tick_slicer_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]  reload_o,
    output ctrl_t             ctrl_o,
    output logic              start_o,
    output logic              ack_o
);
    typedef struct packed {
        logic [CNT_W-1:0] reload;
        ctrl_t            ctrl;
    } cfg_t;

    cfg_t     cfg_d, cfg_q;
    reg_idx_e idx;
    logic     wr_en;
    logic     unused_bus;

    assign unused_bus = ^{bus_addr, bus_wdata};
    assign idx        = reg_idx_e'(bus_addr[IDX_LSB +: REG_IDX_W]);
    assign wr_en      = bus_sel && bus_wr;

    always_comb begin
        cfg_d   = cfg_q;
        start_o = 1'b0;
        ack_o   = 1'b0;
        if (wr_en) begin
            case (idx)
                IDX_RELOAD: cfg_d.reload = bus_wdata[CNT_W-1:0];
                IDX_CTRL: begin
                    cfg_d.ctrl.ien = bus_wdata[BIT_IEN];
                    cfg_d.ctrl.ten = bus_wdata[BIT_TEN];
                    cfg_d.ctrl.run = bus_wdata[BIT_RUN];
                    start_o        = bus_wdata[BIT_TEN] && !cfg_q.ctrl.ten;
                end
                IDX_STATUS: ack_o = bus_wdata[BIT_FLAG];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign reload_o = cfg_q.reload;
    assign ctrl_o   = cfg_q.ctrl;

    // R3: a start strobe leaves the timer enabled
    assert_start_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> ctrl_o.ten);
endmodule

// File: rtl/tick_slicer_core.sv
module tick_slicer_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ten_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             start_i,
    input  logic             ack_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } core_t;

    core_t st_d, st_q;
    logic  expire;

    assign expire = ten_i && (st_q.cnt == ONE);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.cnt = reload_i;
        end else if (ten_i) begin
            if (st_q.cnt != '0) begin
                if (expire && run_i) st_d.cnt = reload_i;
                else                 st_d.cnt = st_q.cnt - ONE;
            end else if (!run_i && ack_i) begin
                st_d.cnt = reload_i;
            end
        end
        if (ack_i)  st_d.flag = 1'b0;
        if (expire) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign flag_o = st_q.flag;

    assert_expiry_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ten_i && st_q.cnt == ONE) |=> flag_o);

    assert_ack_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ten_i && !run_i && st_q.cnt == '0 && !ack_i && !start_i) |=> (cnt_o == '0));

    assert_periodic_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ten_i && run_i && st_q.cnt == ONE) |=> (cnt_o == $past(reload_i)));

    assert_flag_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i && !(ten_i && st_q.cnt == ONE)) |=> $stable(flag_o));

    assert_frozen_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ten_i && !start_i) |=> $stable(cnt_o));

    assert_collision_keeps_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && ten_i && st_q.cnt == ONE) |=> flag_o);
endmodule

// File: rtl/tick_slicer.sv
module tick_slicer
    import tick_slicer_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    ctrl_t            ctrl;
    logic             start;
    logic             ack;
    logic             flag;
    reg_idx_e         idx;

    tick_slicer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .reload_o  (reload),
        .ctrl_o    (ctrl),
        .start_o   (start),
        .ack_o     (ack)
    );

    tick_slicer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ten_i    (ctrl.ten),
        .run_i    (ctrl.run),
        .reload_i (reload),
        .start_i  (start),
        .ack_i    (ack),
        .cnt_o    (cnt),
        .flag_o   (flag)
    );

    assign idx = reg_idx_e'(bus_addr[IDX_LSB +: REG_IDX_W]);

    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_RELOAD: bus_rdata[CNT_W-1:0] = reload;
            IDX_CTRL: begin
                bus_rdata[BIT_IEN] = ctrl.ien;
                bus_rdata[BIT_TEN] = ctrl.ten;
                bus_rdata[BIT_RUN] = ctrl.run;
            end
            IDX_COUNT:  bus_rdata[CNT_W-1:0] = cnt;
            IDX_STATUS: bus_rdata[BIT_FLAG]  = flag;
            default: ;
        endcase
    end

    assign irq = flag && ctrl.ien;

    assert_ctrl_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == IDX_CTRL) |-> (bus_rdata[DATA_W-1:BIT_RUN+1] == '0 && bus_rdata[BIT_IEN-1:0] == '0));

    assert_irq_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl.ien && flag));
endmodule

// File: tb/sim_tick_slicer.sv
module sim_tick_slicer;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_RELOAD = 4'h0, A_CTRL = 4'h4, A_COUNT = 4'h8, A_STAT = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int total = 0;
    int bad = 0;
    logic [31:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_slicer u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_ctrl(input bit ien, input bit ten, input bit run);
        return {5'b0, run, ten, ien, 24'b0};
    endfunction

    function automatic logic [31:0] exp_stat(input bit f);
        return {7'b0, f, 24'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset values
        rd(A_RELOAD, v); check("R1 reload", v, 32'h0);
        rd(A_CTRL, v);   check("R1 ctrl", v, 32'h0);
        rd(A_COUNT, v);  check("R1 count", v, 32'h0);
        rd(A_STAT, v);   check("R1 status", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2: readback and reserved control bits
        wr(A_RELOAD, 32'h0008BD36);
        rd(A_RELOAD, v); check("R2 reload readback", v, 32'h0008BD36);
        wr(A_CTRL, 32'hFFFFFFFF);
        rd(A_CTRL, v); check("R2 ctrl reserved", v, exp_ctrl(1, 1, 1));
        wr(A_CTRL, 32'h0);
        wr(A_STAT, exp_stat(1));

        // R3: load and decrement
        wr(A_RELOAD, 32'd8);
        wr(A_CTRL, exp_ctrl(0, 1, 0));
        rd(A_COUNT, v); check("R3 load", v, 32'd8);
        tick(3);
        rd(A_COUNT, v); check("R3 decrement", v, 32'd5);

        // R4: expiry after N cycles
        tick(4);
        rd(A_STAT, v); check("R4 not yet", v, exp_stat(0));
        tick(1);
        rd(A_STAT, v); check("R4 flag set", v, exp_stat(1));
        rd(A_COUNT, v); check("R4 count zero", v, 32'd0);
        check("R5 irq masked", {31'b0, irq}, 32'h0);

        // R8: zero write has no effect
        wr(A_STAT, 32'h0);
        tick(2);
        rd(A_STAT, v); check("R8 flag kept", v, exp_stat(1));
        rd(A_COUNT, v); check("R8 count kept", v, 32'd0);

        // R5: late interrupt enable
        wr(A_CTRL, exp_ctrl(1, 1, 0));
        check("R5 late enable irq", {31'b0, irq}, 32'h1);

        // R6: wait for acknowledge
        tick(5);
        rd(A_COUNT, v); check("R6 waits at zero", v, 32'd0);
        wr(A_STAT, exp_stat(1));
        check("R6 irq cleared", {31'b0, irq}, 32'h0);
        rd(A_COUNT, v); check("R6 reloaded", v, 32'd8);
        tick(7);
        rd(A_STAT, v); check("R6 early", v, exp_stat(0));
        tick(1);
        rd(A_STAT, v); check("R6 second expiry", v, exp_stat(1));
        check("R5 irq follows flag", {31'b0, irq}, 32'h1);

        // R12: acknowledge while counting does not restart
        wr(A_STAT, exp_stat(1));
        tick(2);
        wr(A_STAT, exp_stat(1));
        rd(A_COUNT, v); check("R12 no restart", v, 32'd5);

        // R9: freeze and reload
        wr(A_CTRL, exp_ctrl(1, 0, 0));
        rd(A_COUNT, v); check("R9 last decrement", v, 32'd4);
        tick(5);
        rd(A_COUNT, v); check("R9 frozen", v, 32'd4);
        wr(A_CTRL, exp_ctrl(1, 1, 0));
        rd(A_COUNT, v); check("R9 reload on enable", v, 32'd8);
        wr(A_CTRL, 32'h0);
        wr(A_STAT, exp_stat(1));

        // R7: periodic mode
        wr(A_RELOAD, 32'd6);
        wr(A_CTRL, exp_ctrl(1, 1, 1));
        tick(5);
        rd(A_STAT, v); check("R7 early", v, exp_stat(0));
        tick(1);
        rd(A_STAT, v); check("R7 first expiry", v, exp_stat(1));
        rd(A_COUNT, v); check("R7 auto reload", v, 32'd6);
        tick(6);
        rd(A_COUNT, v); check("R7 reload without ack", v, 32'd6);

        // R10: acknowledge on the expiry clock
        tick(5);
        wr(A_STAT, exp_stat(1));
        rd(A_STAT, v); check("R10 flag kept", v, exp_stat(1));
        check("R10 irq kept", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h0);
        wr(A_STAT, exp_stat(1));

        // R11: zero reload
        wr(A_RELOAD, 32'd0);
        wr(A_CTRL, exp_ctrl(1, 1, 0));
        tick(20);
        rd(A_STAT, v); check("R11 no expiry", v, exp_stat(0));
        wr(A_CTRL, 32'h0);

        // Random trials for R4, R6 and R7
        for (int t = 0; t < 40; t++) begin
            int n;
            int l;
            bit run;
            bit ien;
            n   = 3 + int'($urandom_range(17));
            run = bit'($urandom_range(1));
            ien = bit'($urandom_range(1));
            l   = int'($urandom_range(n - 2));
            wr(A_RELOAD, n);
            wr(A_CTRL, exp_ctrl(ien, 1, run));
            tick(n - 1);
            rd(A_STAT, v); check("R4 random early", v, exp_stat(0));
            tick(1);
            rd(A_STAT, v); check("R4 random expiry", v, exp_stat(1));
            check("R5 random irq", {31'b0, irq}, {31'b0, ien});
            tick(l);
            wr(A_STAT, exp_stat(1));
            if (run) begin
                rd(A_COUNT, v); check("R7 random count", v, n - l - 1);
                if (n - l - 2 > 0) begin
                    tick(n - l - 2);
                    rd(A_STAT, v); check("R7 random early", v, exp_stat(0));
                end
                tick(1);
                rd(A_STAT, v); check("R7 random expiry", v, exp_stat(1));
            end else begin
                rd(A_COUNT, v); check("R6 random reload", v, n);
                tick(n - 1);
                rd(A_STAT, v); check("R6 random early", v, exp_stat(0));
                tick(1);
                rd(A_STAT, v); check("R6 random expiry", v, exp_stat(1));
            end
            wr(A_CTRL, 32'h0);
            wr(A_STAT, exp_stat(1));
        end

        finish_run();
    end
endmodule